// File: doc/BRIEF.md
# Five-Level Single-Carrier PWM Gate Generator

This block drives the eight gates of a five-level inverter stage. The stage is an H-bridge fed from a split dc link through two pairs of link switches. One triangular carrier serves all of the link switches. It is an up/down counter that runs from 0 to `CMAX` and back.

A signed reference word is sampled once per carrier period, at the carrier valley. Its sign picks which diagonal of the H-bridge conducts. Its magnitude picks one of two amplitude bands:
- **Low band:** the output moves between 0 and half the link voltage.
- **High band:** the output moves between half and full link voltage.

The two link switches take turns in each carrier period so that the two link capacitors are discharged equally. A one-bit turn flag flips at every carrier peak. In the low band, the switch selected by the flag is the one that pulses on. In the high band, the selected switch is the one that drops out outside the pulse, while the other stays on. Each link switch has a complementary partner gate. When enable is low, every gate is held off.

Top module: `five_level_pwm`

## Requirements
- R1: While reset is high and in the first cycle after it, all eight gate outputs are 0. Reset clears the turn flag so that the upper link switch (`linkUpOn`) is the selected one in the first carrier period.
- R2: When enabled, the output level is (`linkUpOn` + `linkDnOn`) half-steps. Its sign is + when `legAHigh` is on and − when `legALow` is on. The level is always one of −2, −1, 0, +1, +2 and equals the level expected from the sampled reference and the carrier.
- R3: The carrier counts 0,1,…,CMAX,CMAX−1,…,1,0,… with a period of 2·CMAX cycles, starting at 0 after reset. The reference is sampled in the cycle in which the carrier is 0, and it is used from the next cycle until the next valley.
- R4: When enabled, a sampled reference ≥ 0 gives `legAHigh`=`legBLow`=1 and `legALow`=`legBHigh`=0. A negative reference gives the opposite pair. The two gates of one leg are never on together.
- R5: When enabled, `linkUpOff` is the inverse of `linkUpOn`, and `linkDnOff` is the inverse of `linkDnOn`.
- R6: In the low band (0 ≤ |ref| < CMAX), the pulse is (|ref| > carrier). During the pulse, only the selected link switch is on; outside the pulse, both are off.
- R7: In the high band (|ref| ≥ CMAX), the pulse is (|ref| − CMAX > carrier). During the pulse, both link switches are on; outside it, only the unselected switch is on.
- R8: The turn flag flips once per carrier period, at the carrier peak. Flag 0 selects the upper switch and flag 1 selects the lower one.
- R9: When enable is low, all eight gates are 0 one cycle later. Enable does not stop the carrier.
- R10: Gate outputs are registered. They reflect the carrier value, the turn flag and the enable of the previous cycle.
- R11: Band edges: ref = 0 is positive polarity at level 0; ref = +CMAX is the high band at constant level +1; ref = −CMAX is the high band at constant level −1; ref = −CMAX+1 is the low band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Gate enable; low forces all gates off |
| refIn | input | REF_W | Signed reference, sampled at the carrier valley |
| legAHigh | output | 1 | H-bridge leg A upper gate |
| legALow | output | 1 | H-bridge leg A lower gate |
| legBHigh | output | 1 | H-bridge leg B upper gate |
| legBLow | output | 1 | H-bridge leg B lower gate |
| linkUpOn | output | 1 | Upper link switch gate |
| linkUpOff | output | 1 | Complement partner of the upper link switch |
| linkDnOn | output | 1 | Lower link switch gate |
| linkDnOff | output | 1 | Complement partner of the lower link switch |

## Verification
Every gate is due exactly one rising edge after the carrier count, turn flag and enable that produce it. A new reference affects the gates only from the cycle after the next carrier valley. The bench keeps an arithmetic model that is advanced on each rising edge with the same one-edge delay, and it drives inputs and compares outputs on falling edges. The bench sweeps every reference from −20 to +20 (with CMAX = 8), plus both extremes of the word, for two full carrier periods each. This covers both turn-flag values in both bands and across both signs.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;
  // Strobes from the carrier datapath to the gate control
  typedef struct packed {
    logic pulse;     // duty value above carrier
    logic positive;  // sampled reference >= 0
    logic highBand;  // |ref| >= carrier peak
    logic atPeak;    // carrier at its top value
  } bandStrb_t;
endpackage

// File: rtl/fpwm_carrier_path.sv
module fpwm_carrier_path
  import fpwm_pkg::*;
#(
  parameter int REF_W = 12,
  parameter int CMAX  = 1000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [REF_W-1:0] refIn,
  output bandStrb_t               strb
);
  localparam int CNT_W = $clog2(CMAX + 1);
  localparam int MAG_W = REF_W + 1;
  localparam int CW    = (MAG_W > CNT_W) ? MAG_W : CNT_W;
  localparam logic [CNT_W-1:0] PEAK = CNT_W'(CMAX);
  localparam logic [CW-1:0]    PEAKW = CW'(CMAX);

  logic [CNT_W-1:0]    carrier;
  logic                countUp;
  logic signed [REF_W-1:0] refHeld;

  // Triangular carrier, 0..CMAX..0
  always_ff @(posedge clk) begin
    if (rst) begin
      carrier <= '0;
      countUp <= 1'b1;
    end else if (countUp) begin
      carrier <= carrier + 1'b1;
      if (carrier == PEAK - 1'b1) countUp <= 1'b0;
    end else begin
      carrier <= carrier - 1'b1;
      if (carrier == CNT_W'(1)) countUp <= 1'b1;
    end
  end

  // Reference held for one whole carrier period
  always_ff @(posedge clk) begin
    if (rst)                 refHeld <= '0;
    else if (carrier == '0)  refHeld <= refIn;
  end

  logic signed [MAG_W-1:0] refExt;
  logic [CW-1:0] magW, dutyW, carW;
  logic          isPos, isHigh;

  always_comb begin
    refExt = {refHeld[REF_W-1], refHeld};
    isPos  = ~refHeld[REF_W-1];
    magW   = isPos ? CW'(unsigned'(refExt)) : CW'(unsigned'(-refExt));
    isHigh = (magW >= PEAKW);
    dutyW  = isHigh ? (magW - PEAKW) : magW;
    carW   = CW'(carrier);
    strb.pulse    = (dutyW > carW);
    strb.positive = isPos;
    strb.highBand = isHigh;
    strb.atPeak   = (carrier == PEAK);
  end

  // R3
  carrier_range_chk: assert property (@(posedge clk) disable iff (rst)
    carrier <= PEAK);
  // R3
  carrier_turn_chk: assert property (@(posedge clk) disable iff (rst)
    (carrier == PEAK) |=> (carrier == PEAK - 1'b1));
  // R3
  carrier_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (carrier == '0) |=> (carrier == CNT_W'(1)));
  // R3
  ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(carrier) != '0) |-> $stable(refHeld));
endmodule

// File: rtl/fpwm_gate_ctrl.sv
module fpwm_gate_ctrl
  import fpwm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  bandStrb_t strb,
  output logic      legAHigh,
  output logic      legALow,
  output logic      legBHigh,
  output logic      legBLow,
  output logic      linkUpOn,
  output logic      linkUpOff,
  output logic      linkDnOn,
  output logic      linkDnOff
);
  logic turnFlag;
  logic selUp;
  logic upNext, dnNext;

  always_comb begin
    selUp = ~turnFlag;
    if (strb.highBand) begin
      // selected switch drops out between pulses
      upNext = strb.pulse | ~selUp;
      dnNext = strb.pulse |  selUp;
    end else begin
      // selected switch alone carries the pulse
      upNext = strb.pulse &  selUp;
      dnNext = strb.pulse & ~selUp;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      turnFlag  <= 1'b0;
      legAHigh  <= 1'b0;
      legALow   <= 1'b0;
      legBHigh  <= 1'b0;
      legBLow   <= 1'b0;
      linkUpOn  <= 1'b0;
      linkUpOff <= 1'b0;
      linkDnOn  <= 1'b0;
      linkDnOff <= 1'b0;
    end else begin
      turnFlag <= turnFlag ^ strb.atPeak;
      if (en) begin
        legAHigh  <=  strb.positive;
        legBLow   <=  strb.positive;
        legALow   <= ~strb.positive;
        legBHigh  <= ~strb.positive;
        linkUpOn  <=  upNext;
        linkUpOff <= ~upNext;
        linkDnOn  <=  dnNext;
        linkDnOff <= ~dnNext;
      end else begin
        legAHigh  <= 1'b0;
        legALow   <= 1'b0;
        legBHigh  <= 1'b0;
        legBLow   <= 1'b0;
        linkUpOn  <= 1'b0;
        linkUpOff <= 1'b0;
        linkDnOn  <= 1'b0;
        linkDnOff <= 1'b0;
      end
    end
  end

  // R4
  leg_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(legAHigh && legALow) && !(legBHigh && legBLow));
  // R9
  disable_off_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> !(legAHigh || legALow || legBHigh || legBLow ||
                     linkUpOn || linkUpOff || linkDnOn || linkDnOff));
  // R8
  turn_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(strb.atPeak) |-> $stable(turnFlag));
  // R6
  low_single_chk: assert property (@(posedge clk) disable iff (rst)
    $past(en && !strb.highBand) |-> !(linkUpOn && linkDnOn));
  // R7
  high_floor_chk: assert property (@(posedge clk) disable iff (rst)
    $past(en && strb.highBand) |-> (linkUpOn || linkDnOn));
endmodule

// File: rtl/five_level_pwm.sv
module five_level_pwm
  import fpwm_pkg::*;
#(
  parameter int REF_W = 12,
  parameter int CMAX  = 1000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [REF_W-1:0] refIn,
  output logic                    legAHigh,
  output logic                    legALow,
  output logic                    legBHigh,
  output logic                    legBLow,
  output logic                    linkUpOn,
  output logic                    linkUpOff,
  output logic                    linkDnOn,
  output logic                    linkDnOff
);
  bandStrb_t strb;

  fpwm_carrier_path #(.REF_W(REF_W), .CMAX(CMAX)) i_path (
    .clk   (clk),
    .rst   (rst),
    .refIn (refIn),
    .strb  (strb)
  );

  fpwm_gate_ctrl i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .strb      (strb),
    .legAHigh  (legAHigh),
    .legALow   (legALow),
    .legBHigh  (legBHigh),
    .legBLow   (legBLow),
    .linkUpOn  (linkUpOn),
    .linkUpOff (linkUpOff),
    .linkDnOn  (linkDnOn),
    .linkDnOff (linkDnOff)
  );
endmodule

// File: tb/test_five_level_pwm.sv
`timescale 1ns/1ps
module test_five_level_pwm;
  localparam int REF_W = 6;
  localparam int CMAX  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic signed [REF_W-1:0] refIn = '0;
  logic legAHigh, legALow, legBHigh, legBLow;
  logic linkUpOn, linkUpOff, linkDnOn, linkDnOff;

  five_level_pwm #(.REF_W(REF_W), .CMAX(CMAX)) i_five_level_pwm (
    .clk(clk), .rst(rst), .en(en), .refIn(refIn),
    .legAHigh(legAHigh), .legALow(legALow), .legBHigh(legBHigh), .legBLow(legBLow),
    .linkUpOn(linkUpOn), .linkUpOff(linkUpOff), .linkDnOn(linkDnOn), .linkDnOff(linkDnOff)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 0;

  // Reference model, advanced on each rising edge
  int mCnt = 0, mUp = 1, mTog = 0, mRef = 0;
  int expUp = 0, expDn = 0, expPos = 0, expHigh = 0, expEn = 0, expLevel = 0;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      mCnt = 0; mUp = 1; mTog = 0; mRef = 0;
      expEn = 0; expUp = 0; expDn = 0; expPos = 1; expHigh = 0; expLevel = 0;
    end else begin
      int mag, duty, pulse, selUp;
      expEn  = en;
      expPos = (mRef >= 0);
      mag    = expPos ? mRef : -mRef;
      expHigh = (mag >= CMAX);
      duty   = expHigh ? mag - CMAX : mag;
      pulse  = (duty > mCnt);
      selUp  = (mTog == 0);
      if (expHigh) begin
        expUp = (pulse || !selUp);
        expDn = (pulse || selUp);
      end else begin
        expUp = (pulse && selUp);
        expDn = (pulse && !selUp);
      end
      expLevel = (expUp + expDn) * (expPos ? 1 : -1);
      if (mCnt == 0) mRef = int'(refIn);
      if (mCnt == CMAX) mTog = 1 - mTog;
      if (mUp == 1) begin
        mCnt++;
        if (mCnt == CMAX) mUp = 0;
      end else begin
        mCnt--;
        if (mCnt == 0) mUp = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic checkNow(input bit inReset);
    int allG;
    int level;
    allG = {legAHigh, legALow, legBHigh, legBLow, linkUpOn, linkUpOff, linkDnOn, linkDnOff};
    if (inReset || !expEn) begin
      // R1 reset state / R9 disabled outputs
      chk(allG == 0, inReset ? "R1 gates during reset" : "R9 gates while disabled", allG, 0);
    end else begin
      // R4 polarity steering
      chk({legAHigh, legALow, legBHigh, legBLow} == (expPos ? 4'b1001 : 4'b0110),
          "R4 leg pattern", {legAHigh, legALow, legBHigh, legBLow}, expPos ? 9 : 6);
      // R5 complement partners
      chk(linkUpOff == !linkUpOn && linkDnOff == !linkDnOn,
          "R5 link complements", {linkUpOn, linkUpOff, linkDnOn, linkDnOff}, 0);
      // R6/R7 band behaviour, with R8 turn order, R3 carrier timing and R10 latency
      chk(linkUpOn == expUp[0] && linkDnOn == expDn[0],
          expHigh ? "R7 R8 R3 R10 high band link gates" : "R6 R8 R3 R10 low band link gates",
          {linkUpOn, linkDnOn}, {expUp[0], expDn[0]});
      // R2 five-level output, R11 band edges
      level = (int'(linkUpOn) + int'(linkDnOn)) * (legAHigh ? 1 : -1);
      chk(level == expLevel && level >= -2 && level <= 2, "R2 R11 output level", level, expLevel);
    end
  endtask

  task automatic run(input int n, input bit inReset);
    repeat (n) begin
      @(negedge clk);
      checkNow(inReset);
    end
  endtask

  always @(posedge clk) begin
    if (!finished && cycles > 100000) begin
      finished = 1;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks + 1);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; en = 1'b1; refIn = 6'sd20;
    run(4, 1'b1);                 // R1
    @(negedge clk); rst = 1'b0;
    // R1: first cycle after reset, gates still off
    chk({legAHigh, legALow, legBHigh, legBLow, linkUpOn, linkUpOff, linkDnOn, linkDnOff} == 0,
        "R1 gates after reset", 1, 0);
    run(4 * CMAX, 1'b0);
    // R2 R4 R6 R7 R11 sweep across both bands and signs
    for (int r = -20; r <= 20; r++) begin
      refIn = REF_W'(r);
      run(4 * CMAX, 1'b0);
    end
    // extremes of the reference word
    refIn = -6'sd32; run(4 * CMAX, 1'b0);
    refIn =  6'sd31; run(4 * CMAX, 1'b0);
    // R9: enable low mid-period, carrier keeps running
    refIn = 6'sd5; run(4 * CMAX, 1'b0);
    en = 1'b0; run(3 * CMAX + 3, 1'b0);
    en = 1'b1; run(4 * CMAX, 1'b0);
    // R1: reset mid-run clears turn flag and carrier
    refIn = 6'sd12;
    rst = 1'b1; run(3, 1'b1);
    rst = 1'b0; run(4 * CMAX, 1'b0);
    refIn = -6'sd3; run(4 * CMAX, 1'b0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule